// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Target Model

This block models the device end of a three-wire serial EEPROM as synchronous logic. A fast system clock samples the chip-select, shift-clock and data-in lines through two-stage synchronizers, and every action happens on a detected rising edge of the shift clock. A command is a start bit, a two-bit opcode and an address field. A write command is followed by a data word. Reads return one word or a continuous stream of words. Programming commands change a small register array and then hold the block busy for a set number of system-clock cycles.

A strap input selects 16-bit words (strap high) or 8-bit words (strap low). The storage holds `2**STORE_LOG2` bytes. Address bits above the storage size alias onto it. A 16-bit word `a` occupies byte `2a` (low half) and byte `2a+1` (high half). The data-out line is modelled as a value plus an output enable. Programming is locked after reset and must be unlocked by command.

Top module: `ee3w_target`

## Requirements
- R1: After reset the output enable is low and programming is locked, so a write sent before any unlock command leaves memory at its reset value of all ones.
- R2: With chip select high, the first 1 sampled on DI at a rising SK edge is the start bit. A 2-bit opcode follows, MSB first, then the address MSB first: 10 bits with the strap high, 11 bits with the strap low.
- R3: Opcode 10 is a read. After the last address bit the output is enabled and shows one 0 dummy bit. Each following SK rising edge moves DO to the next data bit, MSB first.
- R4: While chip select stays high after a word, the next address (modulo the address field) follows at once, with no dummy bit in between.
- R5: Opcode 00 with the top two address bits 11 unlocks programming, and with 00 locks it. While locked, write, erase, erase-all and write-all do nothing.
- R6: Opcode 01 followed by a full data word (16 or 8 bits, MSB first) stores that word at the address.
- R7: Opcode 11 sets every bit of the addressed word to 1.
- R8: Opcode 00 with top address bits 10 sets all storage to ones. With top address bits 01 it takes one data word and stores it at every address.
- R9: If chip select is dropped and then raised again while a programming cycle runs, DO is enabled and reads 0. It reads 1 once the cycle has finished.
- R10: If chip select is raised only after the programming cycle has finished, DO stays disabled.
- R11: Any command sent while a programming cycle runs is ignored.
- R12: Dropping chip select aborts the command in progress and disables DO. A write whose data bits are not all received changes nothing.
- R13: A read works whether programming is locked or unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SK |
| rstN | input | 1 | Active-low reset |
| csIn | input | 1 | Chip select, active high |
| skIn | input | 1 | Serial shift clock |
| diIn | input | 1 | Serial data in |
| orgWide | input | 1 | Organization strap: 1 = 16-bit words, 0 = 8-bit words |
| doOut | output | 1 | Serial data out value |
| doOe | output | 1 | Output enable for doOut |

## Verification
Reads are run with a single word, with two words in one chip-select window, and in both organizations. This separates errors in the dummy bit, in bit order and in address stepping. Writes are sent locked and unlocked, during a busy period, and cut short by chip select. This shows that only a complete, unlocked, non-busy command changes storage. Status is probed once during a programming cycle and once after it, which separates the busy report from the case where no status is driven. Erase, erase-all and write-all are checked with words whose expected contents differ from what any other command would leave.

// File: rtl/ee3w_pkg.sv
package ee3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_READ,
    ST_DONE
  } ctlState_t;

  typedef struct packed {
    logic rdLoad;
    logic rdShift;
    logic dataShift;
    logic wrWord;
    logic wrAll;
    logic eraseOp;
  } dpCtl_t;

  localparam int ADDR_FIELD_MAX = 11;
endpackage

// File: rtl/ee3w_ctrl.sv
module ee3w_ctrl
  import ee3w_pkg::*;
#(
  parameter int PROG_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        csS,
  input  logic        csRise,
  input  logic        csFall,
  input  logic        skRise,
  input  logic        diS,
  input  logic        wide,
  input  logic        rdBit,
  output dpCtl_t      ctl,
  output logic [ADDR_FIELD_MAX-1:0] addrOut,
  output logic        doOut,
  output logic        doOe
);
  localparam int PW = $clog2(PROG_CYCLES + 1);

  ctlState_t state;
  logic [4:0]  cnt;
  logic [11:0] cmdReg;
  logic [12:0] newCmd;
  logic [ADDR_FIELD_MAX-1:0] addrReg, addrNext;
  logic [1:0]  opNext, subNext;
  logic [4:0]  cmdBits, dataBits;
  logic        wen, showStatus, allFlag, busy, act, progStart;
  logic        lastCmdBit, lastData;
  logic [PW-1:0] progCnt;

  assign busy     = (progCnt != '0);
  assign act      = skRise && csS;
  assign cmdBits  = wide ? 5'd12 : 5'd13;
  assign dataBits = wide ? 5'd16 : 5'd8;
  assign newCmd   = {cmdReg, diS};
  assign addrNext = wide ? {1'b0, newCmd[9:0]} : newCmd[10:0];
  assign opNext   = wide ? newCmd[11:10] : newCmd[12:11];
  assign subNext  = wide ? newCmd[9:8] : newCmd[10:9];
  assign lastCmdBit = (cnt == cmdBits - 5'd1);
  assign lastData   = (cnt == dataBits - 5'd1);
  assign addrOut  = (state == ST_CMD) ? addrNext : addrReg;

  always_comb begin
    ctl = '0;
    progStart = 1'b0;
    if (act) begin
      unique case (state)
        ST_CMD: if (lastCmdBit) begin
          if (opNext == 2'b10) ctl.rdLoad = 1'b1;
          else if (opNext == 2'b11 && wen) begin
            ctl.wrWord = 1'b1; ctl.eraseOp = 1'b1; progStart = 1'b1;
          end else if (opNext == 2'b00 && subNext == 2'b10 && wen) begin
            ctl.wrAll = 1'b1; ctl.eraseOp = 1'b1; progStart = 1'b1;
          end
        end
        ST_DATA: begin
          ctl.dataShift = 1'b1;
          if (lastData) begin
            ctl.wrWord = ~allFlag;
            ctl.wrAll  = allFlag;
            progStart  = 1'b1;
          end
        end
        ST_READ: ctl.rdShift = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; cnt <= '0; cmdReg <= '0; addrReg <= '0;
      wen <= 1'b0; showStatus <= 1'b0; allFlag <= 1'b0; progCnt <= '0;
    end else begin
      if (progStart) progCnt <= PW'(PROG_CYCLES);
      else if (busy) progCnt <= progCnt - 1'b1;

      if (csFall) begin
        state <= ST_IDLE; cnt <= '0; showStatus <= 1'b0;
      end else if (csRise) begin
        showStatus <= busy;
      end else if (act) begin
        unique case (state)
          ST_IDLE: if (diS && !busy) begin
            state <= ST_CMD; cnt <= '0; showStatus <= 1'b0;
          end
          ST_CMD: begin
            cmdReg <= newCmd[11:0];
            cnt <= cnt + 5'd1;
            if (lastCmdBit) begin
              addrReg <= addrNext;
              cnt <= '0;
              state <= ST_DONE;
              unique case (opNext)
                2'b10: state <= ST_READ;
                2'b01: if (wen) begin state <= ST_DATA; allFlag <= 1'b0; end
                2'b00: begin
                  if (subNext == 2'b11) wen <= 1'b1;
                  else if (subNext == 2'b00) wen <= 1'b0;
                  else if (subNext == 2'b01 && wen) begin
                    state <= ST_DATA; allFlag <= 1'b1;
                  end
                end
                default: ;
              endcase
            end
          end
          ST_DATA: begin
            cnt <= cnt + 5'd1;
            if (lastData) state <= ST_DONE;
          end
          default: ;
        endcase
      end
    end
  end

  assign doOe  = (state == ST_READ) || showStatus;
  assign doOut = (state == ST_READ) ? rdBit : ~busy;

  // R11: while busy, no start bit moves the control out of idle
  p_busy_no_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && state == ST_IDLE) |=> state == ST_IDLE);
  // R12: chip select low releases the data-out line
  p_cs_low_release_r12: assert property (@(posedge clk) disable iff (!rstN)
    !csS |=> !doOe);
  // R5: a programming cycle begins only while unlocked
  p_prog_needs_wen_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(wen));
  // R9: status is shown only when chip select returns during a busy cycle
  p_status_when_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(showStatus) |-> $past(busy));
endmodule

// File: rtl/ee3w_datapath.sv
module ee3w_datapath
  import ee3w_pkg::*;
#(
  parameter int STORE_LOG2 = 6
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpCtl_t      ctl,
  input  logic [ADDR_FIELD_MAX-1:0] addr,
  input  logic        diS,
  input  logic        wide,
  output logic        rdBit
);
  localparam int NBYTES = 2 ** STORE_LOG2;
  localparam int SW = STORE_LOG2;

  logic [7:0]  mem [NBYTES];
  logic [ADDR_FIELD_MAX-1:0] ptr, ptrNext, readAddr;
  logic [15:0] wordReg, fetched, wrData;
  logic [14:0] dShift;
  logic [4:0]  left, dataBits;
  logic [SW-1:0] rIdxN, rIdxLo, rIdxHi, wIdxN, wIdxLo, wIdxHi;

  assign dataBits = wide ? 5'd16 : 5'd8;
  assign ptrNext  = (ptr + 1'b1) & (wide ? 11'h3FF : 11'h7FF);
  assign readAddr = ctl.rdLoad ? addr : ptrNext;
  assign rIdxN  = readAddr[SW-1:0];
  assign rIdxLo = {readAddr[SW-2:0], 1'b0};
  assign rIdxHi = {readAddr[SW-2:0], 1'b1};
  assign wIdxN  = addr[SW-1:0];
  assign wIdxLo = {addr[SW-2:0], 1'b0};
  assign wIdxHi = {addr[SW-2:0], 1'b1};
  assign fetched = wide ? {mem[rIdxHi], mem[rIdxLo]} : {mem[rIdxN], 8'h00};
  assign wrData  = ctl.eraseOp ? 16'hFFFF : {dShift, diS};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NBYTES; i++) mem[i] <= 8'hFF;
      ptr <= '0; wordReg <= '0; left <= '0; rdBit <= 1'b0; dShift <= '0;
    end else begin
      if (ctl.dataShift) dShift <= {dShift[13:0], diS};
      if (ctl.rdLoad) begin
        rdBit <= 1'b0;
        wordReg <= fetched;
        left <= dataBits;
        ptr <= addr;
      end else if (ctl.rdShift) begin
        if (left != '0) begin
          rdBit <= wordReg[15];
          wordReg <= {wordReg[14:0], 1'b0};
          left <= left - 5'd1;
        end else begin
          rdBit <= fetched[15];
          wordReg <= {fetched[14:0], 1'b0};
          left <= dataBits - 5'd1;
          ptr <= ptrNext;
        end
      end
      if (ctl.wrWord) begin
        if (wide) begin
          mem[wIdxHi] <= wrData[15:8];
          mem[wIdxLo] <= wrData[7:0];
        end else begin
          mem[wIdxN] <= wrData[7:0];
        end
      end else if (ctl.wrAll) begin
        for (int i = 0; i < NBYTES; i++)
          mem[i] <= (wide && i[0]) ? wrData[15:8] : wrData[7:0];
      end
    end
  end

  // R3: the first bit after a read command is the 0 dummy
  p_dummy_first_r3: assert property (@(posedge clk) disable iff (!rstN)
    ctl.rdLoad |=> !rdBit);
  // R4: bits still to shift never exceed one word
  p_left_bound_r4: assert property (@(posedge clk) disable iff (!rstN)
    left <= 5'd16);
endmodule

// File: rtl/ee3w_target.sv
module ee3w_target
  import ee3w_pkg::*;
#(
  parameter int STORE_LOG2  = 6,
  parameter int PROG_CYCLES = 1000
) (
  input  logic clk,
  input  logic rstN,
  input  logic csIn,
  input  logic skIn,
  input  logic diIn,
  input  logic orgWide,
  output logic doOut,
  output logic doOe
);
  logic [1:0] csSync, skSync, diSync;
  logic csPrev, skPrev;
  logic csS, skS, diS, csRise, csFall, skRise, rdBit;
  dpCtl_t ctl;
  logic [ADDR_FIELD_MAX-1:0] addr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csSync <= '0; skSync <= '0; diSync <= '0; csPrev <= 1'b0; skPrev <= 1'b0;
    end else begin
      csSync <= {csSync[0], csIn};
      skSync <= {skSync[0], skIn};
      diSync <= {diSync[0], diIn};
      csPrev <= csS;
      skPrev <= skS;
    end
  end

  assign csS = csSync[1];
  assign skS = skSync[1];
  assign diS = diSync[1];
  assign csRise = csS & ~csPrev;
  assign csFall = ~csS & csPrev;
  assign skRise = skS & ~skPrev;

  ee3w_ctrl #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csS(csS), .csRise(csRise), .csFall(csFall),
    .skRise(skRise), .diS(diS), .wide(orgWide), .rdBit(rdBit),
    .ctl(ctl), .addrOut(addr), .doOut(doOut), .doOe(doOe)
  );

  ee3w_datapath #(.STORE_LOG2(STORE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .diS(diS),
    .wide(orgWide), .rdBit(rdBit)
  );
endmodule

// File: tb/ee3w_target_tb.sv
module ee3w_target_tb;
  localparam int CLK_P = 10;
  localparam int PROG  = 400;

  logic clk = 1'b0, rstN = 1'b0, cs = 1'b0, sk = 1'b0, di = 1'b0, orgWide = 1'b1;
  logic doOut, doOe;
  int nChk = 0, nFail = 0;
  logic finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ee3w_target #(.STORE_LOG2(6), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .csIn(cs), .skIn(sk), .diIn(di),
    .orgWide(orgWide), .doOut(doOut), .doOe(doOe)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic smpD, output logic smpOe);
    di = b;
    repeat (4) @(negedge clk);
    smpD = doOut; smpOe = doOe;
    sk = 1'b1;
    repeat (4) @(negedge clk);
    sk = 1'b0;
  endtask

  task automatic sendBits(input logic [15:0] v, input int n);
    logic d, o;
    for (int i = n - 1; i >= 0; i--) sendBit(v[i], d, o);
  endtask

  task automatic csUp();
    repeat (6) @(negedge clk);
    cs = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic csDown();
    repeat (4) @(negedge clk);
    cs = 1'b0; di = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  function automatic int aw();
    return orgWide ? 10 : 11;
  endfunction

  function automatic int dw();
    return orgWide ? 16 : 8;
  endfunction

  task automatic sendCmd(input logic [1:0] op, input logic [10:0] a);
    logic d, o;
    csUp();
    sendBit(1'b1, d, o);
    sendBits({14'd0, op}, 2);
    sendBits({5'd0, a}, aw());
  endtask

  task automatic special(input logic [1:0] sub);
    sendCmd(2'b00, orgWide ? {1'b0, sub, 8'd0} : {sub, 9'd0});
    csDown();
  endtask

  task automatic writeWord(input logic [10:0] a, input logic [15:0] v);
    sendCmd(2'b01, a);
    sendBits(v, dw());
    csDown();
  endtask

  task automatic waitProg();
    repeat (PROG + 40) @(negedge clk);
  endtask

  task automatic readCheck(input string tag, input logic [10:0] a, input int n,
                           input logic [15:0] e0, input logic [15:0] e1);
    logic d, o;
    logic [15:0] v;
    sendCmd(2'b10, a);
    sendBit(1'b0, d, o);
    check({tag, " R3 dummy bit"}, {15'd0, d}, 16'd0);
    check({tag, " R3 output enabled"}, {15'd0, o}, 16'd1);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int i = 0; i < dw(); i++) begin
        sendBit(1'b0, d, o);
        v = {v[14:0], d};
      end
      check($sformatf("%s word %0d", tag, k), v, (k == 0) ? e0 : e1);
    end
    csDown();
  endtask

  task automatic tReset();
    check("R1 reset oe", {15'd0, doOe}, 16'd0);
    writeWord(11'd5, 16'h1234);
    waitProg();
    readCheck("R1 R5 locked write ignored", 11'd5, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic tWriteStatus();
    special(2'b11);
    writeWord(11'd5, 16'hA5C3);
    csUp();
    check("R9 busy oe", {15'd0, doOe}, 16'd1);
    check("R9 busy value", {15'd0, doOut}, 16'd0);
    waitProg();
    check("R9 ready value", {15'd0, doOut}, 16'd1);
    check("R9 ready oe", {15'd0, doOe}, 16'd1);
    csDown();
    check("R12 oe after cs low", {15'd0, doOe}, 16'd0);
    readCheck("R6 R3 read written", 11'd5, 1, 16'hA5C3, 16'h0);
  endtask

  task automatic tSequential();
    writeWord(11'd6, 16'h0F0F);
    waitProg();
    readCheck("R4 sequential", 11'd5, 2, 16'hA5C3, 16'h0F0F);
  endtask

  task automatic tBusyIgnore();
    writeWord(11'd7, 16'h1111);
    writeWord(11'd7, 16'h2222);
    waitProg();
    readCheck("R11 busy command ignored", 11'd7, 1, 16'h1111, 16'h0);
  endtask

  task automatic tLateStatus();
    writeWord(11'd8, 16'h4321);
    waitProg();
    csUp();
    check("R10 no status after done", {15'd0, doOe}, 16'd0);
    csDown();
  endtask

  task automatic tErase();
    sendCmd(2'b11, 11'd5);
    csDown();
    waitProg();
    readCheck("R7 erase word", 11'd5, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic tLock();
    special(2'b00);
    writeWord(11'd6, 16'h0000);
    waitProg();
    readCheck("R5 R13 locked read", 11'd6, 1, 16'h0F0F, 16'h0);
  endtask

  task automatic tAbort();
    logic d, o;
    special(2'b11);
    sendCmd(2'b01, 11'd9);
    sendBits(16'h00AB, 8);
    csDown();
    sendCmd(2'b10, 11'd6);
    sendBit(1'b0, d, o);
    sendBits(16'h0, 3);
    csDown();
    check("R12 read aborted oe", {15'd0, doOe}, 16'd0);
    waitProg();
    readCheck("R12 partial write dropped", 11'd9, 1, 16'hFFFF, 16'h0);
  endtask

  task automatic tNarrow();
    orgWide = 1'b0;
    special(2'b11);
    writeWord(11'h0A, 16'h005A);
    waitProg();
    writeWord(11'h0B, 16'h00A6);
    waitProg();
    readCheck("R2 R4 narrow sequential", 11'h0A, 2, 16'h005A, 16'h00A6);
    sendCmd(2'b00, {2'b01, 9'd0});
    sendBits(16'h003C, 8);
    csDown();
    waitProg();
    readCheck("R8 write all", 11'h3F, 1, 16'h003C, 16'h0);
    sendCmd(2'b00, {2'b10, 9'd0});
    csDown();
    waitProg();
    readCheck("R8 erase all", 11'h20, 1, 16'h00FF, 16'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    tReset();
    tWriteStatus();
    tSequential();
    tBusyIgnore();
    tLateStatus();
    tErase();
    tLock();
    tAbort();
    tNarrow();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nChk++; nFail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule